// File: doc/BRIEF.md
# Parameterized Set-Associative Cache Controller

This block sits between a processor load/store port and a next-level memory. It keeps recently used memory lines in a tag-checked store. Three build parameters fix its geometry: total capacity in bytes, line size in bytes and the number of ways. With one way it is direct-mapped. With as many ways as lines it becomes fully associative, with a single set and no index bits. Any value in between gives an n-way organisation. Every 32-bit request address is split into three fields. The low bits give the byte offset inside a line. The next bits select the set, and the remaining upper bits form the tag. The tag is compared in parallel against all ways of the selected set.

A build-time policy switch gives one of two behaviours. The first is copy-back with fill-on-write: writes only mark the line modified, and a modified line is sent back whole when it is displaced. The second is store-through with no fill on write: every write is also sent onward, and a write that misses leaves the cache unchanged. Victims are chosen by an age-ordered least-recently-used tracker in each set, and an empty way is always used before an occupied one. The controller handles one request at a time and holds its request port not-ready while it is busy with memory.

Top module: `cache_ctrl`

## Requirements
- R1: After reset every line is empty, so the first read of any address misses (hit flag 0). The miss issues one full-line read to the memory at the line-aligned address (offset bits zero) and returns the memory word.
- R2: A read of a word whose line is present returns hit flag 1. It returns the 32-bit word chosen by address bits [offset-1:2] and causes no memory request.
- R3: Set index is taken from the address bits just above the offset, and the tag from all bits above the index. Two lines with equal index and different tags compete for the same set.
- R4: A miss fills an empty way of the set if there is one, before any valid line is displaced.
- R5: When all ways of a set are valid, a miss displaces the way used least recently, where both hits and fills count as uses.
- R6: In copy-back mode a write hit updates only the cached line and marks it modified. No memory write is issued.
- R7: In copy-back mode, displacing a modified line first writes the whole line to its line-aligned address and only then issues the refill read.
- R8: In copy-back mode a write miss fills the line like a read miss and then merges the write. The response carries hit flag 0, and later reads of that line hit.
- R9: Byte enable bit k (k = 0..3) controls byte k (bits 8k+7..8k) of the addressed word. Bytes whose enable is 0 keep their old value.
- R10: In store-through mode every write hit updates the cached word and also sends a single-word write with the same byte enables to the memory. Whole-line writes are never issued.
- R11: In store-through mode a write miss only writes the memory word and installs nothing. A later read of that line misses and returns the new value.
- R12: The request port is ready only when idle. It drops after a request is accepted until the response has been given, and the response valid lasts exactly one cycle.
- R13: Displacing a line that was never written causes no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller idle and accepting a request |
| cpu_req_we | input | 1 | 1 for write, 0 for read |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_wdata | input | 32 | Write word |
| cpu_req_be | input | 4 | Byte enables for writes |
| cpu_rsp_valid | output | 1 | One-cycle response strobe |
| cpu_rsp_rdata | output | 32 | Read word |
| cpu_rsp_hit | output | 1 | 1 when the line was present when the request arrived |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 for write |
| mem_req_line | output | 1 | 1 for whole-line transfer, 0 for single word |
| mem_req_addr | output | 32 | Line-aligned address, or the word address for single-word writes |
| mem_req_wdata | output | LINE_BYTES*8 | Line data, or the word in bits 31:0 |
| mem_req_be | output | 4 | Byte enables for single-word writes |
| mem_rsp_valid | input | 1 | Memory completion strobe, one for each request |
| mem_rsp_rdata | input | LINE_BYTES*8 | Fill data |

## Verification
Two instances are driven, a 2-way copy-back build and a direct-mapped store-through build. Each is fed read and write streams chosen to separate the mechanisms. Repeated offsets inside one line separate word selection from fill behaviour. Alternating lines that share an index separate the set-index split and the preference for empty ways, since the 2-way build keeps both lines and the direct-mapped build thrashes. A reordered sequence of touches on one set, A B A C A B, checks that the tracker displaces the least recently used line rather than the oldest fill. Modified and clean victims, partial byte enables, and write misses under each policy are checked against the memory model's operation order and contents.

// File: rtl/cache_pkg.sv
package cache_pkg;

   localparam int unsigned WORD_BYTES = 4;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_LOOKUP,
      ST_WB_REQ,
      ST_WB_WAIT,
      ST_FILL_REQ,
      ST_FILL_WAIT,
      ST_WT_REQ,
      ST_WT_WAIT,
      ST_RESP
   } ctrl_state_e;

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
   parameter int unsigned SETS     = 4,
   parameter int unsigned WAYS     = 2,
   parameter int unsigned TAG_W    = 25,
   parameter int unsigned IDX_BITS = 2,
   parameter int unsigned WAY_BITS = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [IDX_BITS-1:0]      set_idx,
   input  logic [TAG_W-1:0]         cmp_tag,
   output logic [WAYS-1:0]          hit_vec,
   output logic [WAYS-1:0]          valid_vec,
   output logic [WAYS-1:0]          dirty_vec,
   output logic [WAYS*TAG_W-1:0]    tag_flat,
   input  logic                     install_en,
   input  logic [WAY_BITS-1:0]      install_way,
   input  logic                     mark_dirty_en,
   input  logic [WAY_BITS-1:0]      mark_dirty_way
);

   logic [TAG_W-1:0] tag_q   [SETS][WAYS];
   logic             valid_q [SETS][WAYS];
   logic             dirty_q [SETS][WAYS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
               valid_q[s][w] <= 1'b0;
               dirty_q[s][w] <= 1'b0;
               tag_q[s][w]   <= '0;
            end
         end
      end else begin
         if (install_en) begin
            valid_q[set_idx][install_way] <= 1'b1;
            dirty_q[set_idx][install_way] <= 1'b0;
            tag_q[set_idx][install_way]   <= cmp_tag;
         end
         if (mark_dirty_en) begin
            dirty_q[set_idx][mark_dirty_way] <= 1'b1;
         end
      end
   end

   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         valid_vec[w]               = valid_q[set_idx][w];
         dirty_vec[w]               = dirty_q[set_idx][w];
         hit_vec[w]                 = valid_q[set_idx][w] && (tag_q[set_idx][w] == cmp_tag);
         tag_flat[w*TAG_W +: TAG_W] = tag_q[set_idx][w];
      end
   end

endmodule

// File: rtl/cache_line_store.sv
module cache_line_store #(
   parameter int unsigned SETS       = 4,
   parameter int unsigned WAYS       = 2,
   parameter int unsigned LINE_BYTES = 32,
   parameter int unsigned IDX_BITS   = 2,
   parameter int unsigned WAY_BITS   = 1
) (
   input  logic                      clk,
   input  logic [IDX_BITS-1:0]       set_idx,
   input  logic [WAY_BITS-1:0]       way_sel,
   input  logic [WSEL_W-1:0]         word_sel,
   output logic [31:0]               rd_word,
   output logic [LINE_BITS-1:0]      rd_line,
   input  logic                      fill_en,
   input  logic [LINE_BITS-1:0]      fill_line,
   input  logic                      wr_en,
   input  logic [31:0]               wr_word,
   input  logic [3:0]                wr_be
);

   localparam int unsigned LINE_BITS = LINE_BYTES * 8;
   localparam int unsigned WSEL_W    = $clog2(LINE_BYTES / cache_pkg::WORD_BYTES);

   logic [LINE_BITS-1:0] line_q [SETS][WAYS];

   always_ff @(posedge clk) begin
      if (fill_en) begin
         line_q[set_idx][way_sel] <= fill_line;
      end else if (wr_en) begin
         for (int b = 0; b < 4; b++) begin
            if (wr_be[b]) begin
               line_q[set_idx][way_sel][int'(word_sel)*32 + b*8 +: 8] <= wr_word[b*8 +: 8];
            end
         end
      end
   end

   assign rd_line = line_q[set_idx][way_sel];
   assign rd_word = rd_line[int'(word_sel)*32 +: 32];

endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
   parameter int unsigned SETS     = 4,
   parameter int unsigned WAYS     = 2,
   parameter int unsigned IDX_BITS = 2,
   parameter int unsigned WAY_BITS = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IDX_BITS-1:0] set_idx,
   input  logic [WAYS-1:0]     valid_vec,
   input  logic                touch_en,
   input  logic [WAY_BITS-1:0] touch_way,
   output logic [WAY_BITS-1:0] victim_way
);

   if (WAYS == 1) begin : g_single
      logic unused_ok;
      assign unused_ok  = &{1'b0, clk, rst_n, set_idx, valid_vec, touch_en, touch_way};
      assign victim_way = '0;
   end else begin : g_multi
      localparam int unsigned AGE_W = $clog2(WAYS);

      logic [AGE_W-1:0] age_q [SETS][WAYS];
      logic [AGE_W-1:0] touched_age;

      assign touched_age = age_q[set_idx][touch_way];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
               for (int w = 0; w < WAYS; w++) begin
                  age_q[s][w] <= AGE_W'(w);
               end
            end
         end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
               if (WAY_BITS'(w) == touch_way) begin
                  age_q[set_idx][w] <= '0;
               end else if (age_q[set_idx][w] < touched_age) begin
                  age_q[set_idx][w] <= age_q[set_idx][w] + 1'b1;
               end
            end
         end
      end

      always_comb begin
         logic found;
         found      = 1'b0;
         victim_way = '0;
         for (int w = 0; w < WAYS; w++) begin
            if (!found && !valid_vec[w]) begin
               victim_way = WAY_BITS'(w);
               found      = 1'b1;
            end
         end
         if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
               if (age_q[set_idx][w] == AGE_W'(WAYS - 1)) begin
                  victim_way = WAY_BITS'(w);
               end
            end
         end
      end
   end

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl #(
   parameter int unsigned CACHE_BYTES = 256,
   parameter int unsigned LINE_BYTES  = 32,
   parameter int unsigned WAYS        = 2,
   parameter int unsigned WRITE_BACK  = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cpu_req_valid,
   output logic                      cpu_req_ready,
   input  logic                      cpu_req_we,
   input  logic [31:0]               cpu_req_addr,
   input  logic [31:0]               cpu_req_wdata,
   input  logic [3:0]                cpu_req_be,
   output logic                      cpu_rsp_valid,
   output logic [31:0]               cpu_rsp_rdata,
   output logic                      cpu_rsp_hit,
   output logic                      mem_req_valid,
   input  logic                      mem_req_ready,
   output logic                      mem_req_we,
   output logic                      mem_req_line,
   output logic [31:0]               mem_req_addr,
   output logic [LINE_BYTES*8-1:0]   mem_req_wdata,
   output logic [3:0]                mem_req_be,
   input  logic                      mem_rsp_valid,
   input  logic [LINE_BYTES*8-1:0]   mem_rsp_rdata
);
   import cache_pkg::*;

   localparam int unsigned LINE_BITS = LINE_BYTES * 8;
   localparam int unsigned SETS      = CACHE_BYTES / (LINE_BYTES * WAYS);
   localparam int unsigned OFF_W     = $clog2(LINE_BYTES);
   localparam int unsigned IDX_W     = $clog2(SETS);
   localparam int unsigned TAG_W     = 32 - OFF_W - IDX_W;
   localparam int unsigned IDX_BITS  = (IDX_W == 0) ? 1 : IDX_W;
   localparam int unsigned WAY_BITS  = (WAYS > 1) ? $clog2(WAYS) : 1;
   localparam int unsigned WSEL_W    = OFF_W - 2;

   if ((CACHE_BYTES & (CACHE_BYTES - 1)) != 0) begin : g_bad_size
      $error("cache capacity must be a power of two");
   end
   if ((LINE_BYTES & (LINE_BYTES - 1)) != 0 || LINE_BYTES < 8) begin : g_bad_line
      $error("line size must be a power of two of at least 8 bytes");
   end
   if ((WAYS & (WAYS - 1)) != 0 || WAYS == 0) begin : g_bad_ways
      $error("way count must be a nonzero power of two");
   end
   if (CACHE_BYTES < LINE_BYTES * WAYS) begin : g_bad_geom
      $error("capacity too small for one set");
   end

   ctrl_state_e          state_q, state_d;
   logic                 we_q;
   logic [31:0]          addr_q;
   logic [31:0]          wdata_q;
   logic [3:0]           be_q;
   logic                 miss_q;
   logic [WAY_BITS-1:0]  vic_q;
   logic                 hit_q;
   logic [31:0]          rdata_q;

   logic [TAG_W-1:0]     tag_l;
   logic [IDX_BITS-1:0]  idx_l;
   logic [WSEL_W-1:0]    wsel_l;
   logic [31:0]          fill_base;
   logic [31:0]          wb_base;
   logic [TAG_W-1:0]     wb_tag;

   logic [WAYS-1:0]      hit_vec, valid_vec, dirty_vec;
   logic [WAYS*TAG_W-1:0] tag_flat;
   logic                 any_hit;
   logic [WAY_BITS-1:0]  hit_way;
   logic [WAY_BITS-1:0]  victim_way;
   logic [WAY_BITS-1:0]  way_sel;
   logic [31:0]          rd_word;
   logic [LINE_BITS-1:0] rd_line;

   logic                 do_install, do_dirty, do_fill, do_word_wr, do_touch;

   assign tag_l  = addr_q[31 -: TAG_W];
   assign wsel_l = addr_q[OFF_W-1:2];
   assign wb_tag = tag_flat[int'(vic_q)*TAG_W +: TAG_W];

   if (IDX_W == 0) begin : g_no_index
      assign idx_l     = '0;
      assign fill_base = {tag_l, {OFF_W{1'b0}}};
      assign wb_base   = {wb_tag, {OFF_W{1'b0}}};
   end else begin : g_index
      assign idx_l     = addr_q[OFF_W +: IDX_W];
      assign fill_base = {tag_l, idx_l, {OFF_W{1'b0}}};
      assign wb_base   = {wb_tag, idx_l, {OFF_W{1'b0}}};
   end

   cache_tag_store #(
      .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .IDX_BITS(IDX_BITS), .WAY_BITS(WAY_BITS)
   ) u_tags (
      .clk            (clk),
      .rst_n          (rst_n),
      .set_idx        (idx_l),
      .cmp_tag        (tag_l),
      .hit_vec        (hit_vec),
      .valid_vec      (valid_vec),
      .dirty_vec      (dirty_vec),
      .tag_flat       (tag_flat),
      .install_en     (do_install),
      .install_way    (vic_q),
      .mark_dirty_en  (do_dirty),
      .mark_dirty_way (hit_way)
   );

   cache_line_store #(
      .SETS(SETS), .WAYS(WAYS), .LINE_BYTES(LINE_BYTES), .IDX_BITS(IDX_BITS), .WAY_BITS(WAY_BITS)
   ) u_data (
      .clk       (clk),
      .set_idx   (idx_l),
      .way_sel   (way_sel),
      .word_sel  (wsel_l),
      .rd_word   (rd_word),
      .rd_line   (rd_line),
      .fill_en   (do_fill),
      .fill_line (mem_rsp_rdata),
      .wr_en     (do_word_wr),
      .wr_word   (wdata_q),
      .wr_be     (be_q)
   );

   cache_lru #(
      .SETS(SETS), .WAYS(WAYS), .IDX_BITS(IDX_BITS), .WAY_BITS(WAY_BITS)
   ) u_lru (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_idx    (idx_l),
      .valid_vec  (valid_vec),
      .touch_en   (do_touch),
      .touch_way  (hit_way),
      .victim_way (victim_way)
   );

   assign any_hit = |hit_vec;

   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) hit_way = WAY_BITS'(w);
      end
   end

   assign way_sel = (state_q == ST_LOOKUP) ? hit_way : vic_q;

   always_comb begin
      state_d    = state_q;
      do_install = 1'b0;
      do_dirty   = 1'b0;
      do_fill    = 1'b0;
      do_word_wr = 1'b0;
      do_touch   = 1'b0;
      unique case (state_q)
         ST_IDLE: if (cpu_req_valid) state_d = ST_LOOKUP;
         ST_LOOKUP: begin
            if (any_hit) begin
               do_touch = 1'b1;
               if (we_q) begin
                  do_word_wr = 1'b1;
                  if (WRITE_BACK != 0) begin
                     do_dirty = 1'b1;
                     state_d  = ST_RESP;
                  end else begin
                     state_d  = ST_WT_REQ;
                  end
               end else begin
                  state_d = ST_RESP;
               end
            end else if (we_q && WRITE_BACK == 0) begin
               state_d = ST_WT_REQ;
            end else if (WRITE_BACK != 0 && valid_vec[victim_way] && dirty_vec[victim_way]) begin
               state_d = ST_WB_REQ;
            end else begin
               state_d = ST_FILL_REQ;
            end
         end
         ST_WB_REQ:    if (mem_req_ready) state_d = ST_WB_WAIT;
         ST_WB_WAIT:   if (mem_rsp_valid) state_d = ST_FILL_REQ;
         ST_FILL_REQ:  if (mem_req_ready) state_d = ST_FILL_WAIT;
         ST_FILL_WAIT: begin
            if (mem_rsp_valid) begin
               do_fill    = 1'b1;
               do_install = 1'b1;
               state_d    = ST_LOOKUP;
            end
         end
         ST_WT_REQ:    if (mem_req_ready) state_d = ST_WT_WAIT;
         ST_WT_WAIT:   if (mem_rsp_valid) state_d = ST_RESP;
         ST_RESP:      state_d = ST_IDLE;
         default:      state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         we_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         be_q    <= '0;
         miss_q  <= 1'b0;
         vic_q   <= '0;
         hit_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && cpu_req_valid) begin
            we_q    <= cpu_req_we;
            addr_q  <= cpu_req_addr;
            wdata_q <= cpu_req_wdata;
            be_q    <= cpu_req_be;
            miss_q  <= 1'b0;
         end
         if (state_q == ST_LOOKUP) begin
            if (any_hit) begin
               hit_q   <= !miss_q;
               rdata_q <= rd_word;
            end else begin
               hit_q  <= 1'b0;
               miss_q <= 1'b1;
               vic_q  <= victim_way;
            end
         end
      end
   end

   assign cpu_req_ready = (state_q == ST_IDLE);
   assign cpu_rsp_valid = (state_q == ST_RESP);
   assign cpu_rsp_rdata = rdata_q;
   assign cpu_rsp_hit   = hit_q;

   assign mem_req_valid = (state_q == ST_WB_REQ) || (state_q == ST_FILL_REQ) || (state_q == ST_WT_REQ);
   assign mem_req_we    = (state_q == ST_WB_REQ) || (state_q == ST_WT_REQ);
   assign mem_req_line  = (state_q == ST_WB_REQ) || (state_q == ST_FILL_REQ);
   assign mem_req_be    = (state_q == ST_WT_REQ) ? be_q : 4'hF;

   always_comb begin
      unique case (state_q)
         ST_WB_REQ: begin
            mem_req_addr  = wb_base;
            mem_req_wdata = rd_line;
         end
         ST_WT_REQ: begin
            mem_req_addr  = addr_q;
            mem_req_wdata = LINE_BITS'(wdata_q);
         end
         default: begin
            mem_req_addr  = fill_base;
            mem_req_wdata = '0;
         end
      endcase
   end

endmodule

// File: rtl/cache_ctrl_chk.sv
module cache_ctrl_chk #(
   parameter int unsigned LINE_BYTES = 32,
   parameter int unsigned WRITE_BACK = 1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        cpu_req_valid,
   input logic        cpu_req_ready,
   input logic        cpu_rsp_valid,
   input logic        mem_req_valid,
   input logic        mem_req_ready,
   input logic        mem_req_we,
   input logic        mem_req_line,
   input logic [31:0] mem_req_addr
);

   localparam int unsigned OFF_W = $clog2(LINE_BYTES);

   // R1 and R7: line transfers always use a line-aligned address
   a_r1_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_line) |-> (mem_req_addr[OFF_W-1:0] == '0));

   // R6: copy-back builds never send single-word writes
   a_r6_no_word_write: assert property (@(posedge clk) disable iff (!rst_n)
      (WRITE_BACK != 0 && mem_req_valid && mem_req_we) |-> mem_req_line);

   // R10: store-through builds never send whole-line writes
   a_r10_no_line_write: assert property (@(posedge clk) disable iff (!rst_n)
      (WRITE_BACK == 0 && mem_req_valid && mem_req_we) |-> !mem_req_line);

   // R12: busy after acceptance
   a_r12_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready);

   // R12: one-cycle response strobe
   a_r12_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rsp_valid |=> !cpu_rsp_valid);

   // R12: no new request accepted while a response is presented
   a_r12_rsp_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rsp_valid |-> !cpu_req_ready);

   // R12: a memory request holds until taken
   a_r12_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

endmodule

bind cache_ctrl cache_ctrl_chk #(
   .LINE_BYTES(LINE_BYTES),
   .WRITE_BACK(WRITE_BACK)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cpu_req_valid (cpu_req_valid),
   .cpu_req_ready (cpu_req_ready),
   .cpu_rsp_valid (cpu_rsp_valid),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_we    (mem_req_we),
   .mem_req_line  (mem_req_line),
   .mem_req_addr  (mem_req_addr)
);

// File: tb/sim_mem_model.sv
module sim_mem_model #(
   parameter int LINE_BYTES = 32
) (
   input  logic                    clk,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic                    req_we,
   input  logic                    req_line,
   input  logic [31:0]             req_addr,
   input  logic [LINE_BYTES*8-1:0] req_wdata,
   input  logic [3:0]              req_be,
   output logic                    rsp_valid,
   output logic [LINE_BYTES*8-1:0] rsp_rdata
);
   localparam int WPL = LINE_BYTES / 4;

   logic [31:0] words [4096];
   int n_line_rd = 0;
   int n_line_wr = 0;
   int n_word_wr = 0;
   int last_op   = 0;   // 1 line read, 2 line write, 3 word write
   int prev_op   = 0;
   logic [31:0] last_addr = '0;
   int pend = 0;

   assign req_ready = 1'b1;

   initial begin
      for (int i = 0; i < 4096; i++) words[i] = 32'hC000_0000 | i;
      rsp_valid = 1'b0;
      rsp_rdata = '0;
   end

   always @(posedge clk) begin
      rsp_valid <= 1'b0;
      if (pend > 0) begin
         pend <= pend - 1;
         if (pend == 1) rsp_valid <= 1'b1;
      end
      if (req_valid && req_ready) begin
         int base;
         int wi;
         base = int'(req_addr[13:2]) & ~(WPL - 1);
         wi   = int'(req_addr[13:2]);
         pend      <= 2;
         prev_op   <= last_op;
         last_addr <= req_addr;
         if (req_line && !req_we) begin
            n_line_rd <= n_line_rd + 1;
            last_op   <= 1;
            for (int k = 0; k < WPL; k++) rsp_rdata[k*32 +: 32] <= words[base + k];
         end else if (req_line) begin
            n_line_wr <= n_line_wr + 1;
            last_op   <= 2;
            for (int k = 0; k < WPL; k++) words[base + k] <= req_wdata[k*32 +: 32];
         end else begin
            n_word_wr <= n_word_wr + 1;
            last_op   <= 3;
            for (int b = 0; b < 4; b++)
               if (req_be[b]) words[wi][b*8 +: 8] <= req_wdata[b*8 +: 8];
         end
      end
   end
endmodule

// File: tb/sim_cache_ctrl.sv
module sim_cache_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int LB = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   int   sel = 0;
   logic q_valid = 1'b0, q_we = 1'b0;
   logic [31:0] q_addr = '0, q_wd = '0;
   logic [3:0]  q_be = '0;

   logic r0_rdy, r0_rv, r0_hit, r1_rdy, r1_rv, r1_hit;
   logic [31:0] r0_rd, r1_rd;

   logic m0_v, m0_rdy, m0_we, m0_ln, m0_rv, m1_v, m1_rdy, m1_we, m1_ln, m1_rv;
   logic [31:0] m0_a, m1_a;
   logic [3:0]  m0_be, m1_be;
   logic [LB*8-1:0] m0_wd, m0_rd, m1_wd, m1_rd;

   cache_ctrl #(.CACHE_BYTES(256), .LINE_BYTES(LB), .WAYS(2), .WRITE_BACK(1)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cpu_req_valid(q_valid && sel == 0), .cpu_req_ready(r0_rdy), .cpu_req_we(q_we),
      .cpu_req_addr(q_addr), .cpu_req_wdata(q_wd), .cpu_req_be(q_be),
      .cpu_rsp_valid(r0_rv), .cpu_rsp_rdata(r0_rd), .cpu_rsp_hit(r0_hit),
      .mem_req_valid(m0_v), .mem_req_ready(m0_rdy), .mem_req_we(m0_we), .mem_req_line(m0_ln),
      .mem_req_addr(m0_a), .mem_req_wdata(m0_wd), .mem_req_be(m0_be),
      .mem_rsp_valid(m0_rv), .mem_rsp_rdata(m0_rd));

   cache_ctrl #(.CACHE_BYTES(256), .LINE_BYTES(LB), .WAYS(1), .WRITE_BACK(0)) u1 (
      .clk(clk), .rst_n(rst_n),
      .cpu_req_valid(q_valid && sel == 1), .cpu_req_ready(r1_rdy), .cpu_req_we(q_we),
      .cpu_req_addr(q_addr), .cpu_req_wdata(q_wd), .cpu_req_be(q_be),
      .cpu_rsp_valid(r1_rv), .cpu_rsp_rdata(r1_rd), .cpu_rsp_hit(r1_hit),
      .mem_req_valid(m1_v), .mem_req_ready(m1_rdy), .mem_req_we(m1_we), .mem_req_line(m1_ln),
      .mem_req_addr(m1_a), .mem_req_wdata(m1_wd), .mem_req_be(m1_be),
      .mem_rsp_valid(m1_rv), .mem_rsp_rdata(m1_rd));

   sim_mem_model #(.LINE_BYTES(LB)) m0 (
      .clk(clk), .req_valid(m0_v), .req_ready(m0_rdy), .req_we(m0_we), .req_line(m0_ln),
      .req_addr(m0_a), .req_wdata(m0_wd), .req_be(m0_be), .rsp_valid(m0_rv), .rsp_rdata(m0_rd));

   sim_mem_model #(.LINE_BYTES(LB)) m1 (
      .clk(clk), .req_valid(m1_v), .req_ready(m1_rdy), .req_we(m1_we), .req_line(m1_ln),
      .req_addr(m1_a), .req_wdata(m1_wd), .req_be(m1_be), .rsp_valid(m1_rv), .rsp_rdata(m1_rd));

   int n_checks = 0;
   int n_errors = 0;
   bit done = 0;
   logic [31:0] gold0 [int];
   logic [31:0] gold1 [int];
   logic busy_ready;

   function automatic logic [31:0] exp_word(int d, logic [31:0] a);
      int wi;
      wi = int'(a[13:2]);
      if (d == 0 && gold0.exists(wi)) return gold0[wi];
      if (d == 1 && gold1.exists(wi)) return gold1[wi];
      return 32'hC000_0000 | wi;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic access(input int d, input logic we, input logic [31:0] a,
                         input logic [31:0] wd, input logic [3:0] be,
                         output logic [31:0] rd, output logic hit);
      logic [31:0] old;
      @(negedge clk);
      sel = d; q_we = we; q_addr = a; q_wd = wd; q_be = be; q_valid = 1'b1;
      while (!(d == 0 ? r0_rdy : r1_rdy)) @(negedge clk);
      @(negedge clk);
      q_valid = 1'b0;
      busy_ready = (d == 0) ? r0_rdy : r1_rdy;
      while (!(d == 0 ? r0_rv : r1_rv)) @(negedge clk);
      rd  = (d == 0) ? r0_rd : r1_rd;
      hit = (d == 0) ? r0_hit : r1_hit;
      if (we) begin
         old = exp_word(d, a);
         for (int b = 0; b < 4; b++) if (be[b]) old[b*8 +: 8] = wd[b*8 +: 8];
         if (d == 0) gold0[int'(a[13:2])] = old;
         else        gold1[int'(a[13:2])] = old;
      end
   endtask

   task automatic rd_chk(int d, logic [31:0] a, logic exp_hit, string tag);
      logic [31:0] rd;
      logic hit;
      access(d, 1'b0, a, 32'h0, 4'h0, rd, hit);
      chk({tag, " hit"}, 32'(hit), 32'(exp_hit));
      chk({tag, " data"}, rd, exp_word(d, a));
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R12 ready after reset u0", 32'(r0_rdy), 1);
      chk("R12 ready after reset u1", 32'(r1_rdy), 1);
      chk("R12 no rsp after reset", 32'(r0_rv | r1_rv), 0);
   endtask

   task automatic t_cold_miss;
      rd_chk(0, 32'h044, 1'b0, "R1 cold read");
      chk("R12 busy while filling", 32'(busy_ready), 0);
      @(negedge clk);
      chk("R12 rsp one cycle", 32'(r0_rv), 0);
      chk("R1 one line fill", m0.n_line_rd, 1);
      chk("R1 fill aligned", m0.last_addr, 32'h040);
   endtask

   task automatic t_hit_offset;
      rd_chk(0, 32'h048, 1'b1, "R2 word 2");
      rd_chk(0, 32'h05C, 1'b1, "R2 word 7");
      chk("R2 no mem traffic", m0.n_line_rd, 1);
   endtask

   task automatic t_index_split;
      rd_chk(0, 32'h000, 1'b0, "R3 two-way first");
      rd_chk(0, 32'h080, 1'b0, "R4 two-way second");
      rd_chk(0, 32'h000, 1'b1, "R4 first kept");
      rd_chk(0, 32'h080, 1'b1, "R4 second kept");
      rd_chk(1, 32'h000, 1'b0, "R3 dm first");
      rd_chk(1, 32'h100, 1'b0, "R3 dm alias");
      rd_chk(1, 32'h000, 1'b0, "R3 dm conflict");
   endtask

   task automatic t_lru;
      rd_chk(0, 32'h000, 1'b1, "R5 touch A");
      rd_chk(0, 32'h100, 1'b0, "R5 C misses");
      rd_chk(0, 32'h000, 1'b1, "R5 A survives");
      rd_chk(0, 32'h080, 1'b0, "R5 B was displaced");
      chk("R13 clean victims not written", m0.n_line_wr, 0);
   endtask

   task automatic t_wb_write_hit;
      logic [31:0] rd;
      logic hit;
      int ops;
      ops = m0.n_line_rd + m0.n_line_wr + m0.n_word_wr;
      access(0, 1'b1, 32'h004, 32'h1122_3344, 4'b0101, rd, hit);
      chk("R6 write hit flag", 32'(hit), 1);
      chk("R6 no mem traffic", m0.n_line_rd + m0.n_line_wr + m0.n_word_wr, ops);
      chk("R6 memory unchanged", m0.words[1], 32'hC000_0001);
      rd_chk(0, 32'h004, 1'b1, "R9 byte merge copy-back");
      chk("R9 merged value", exp_word(0, 32'h004), 32'hC022_0044);
   endtask

   task automatic t_wb_evict;
      rd_chk(0, 32'h080, 1'b1, "R7 touch other way");
      rd_chk(0, 32'h100, 1'b0, "R7 refill after evict");
      chk("R7 one line write", m0.n_line_wr, 1);
      chk("R7 write before refill", m0.prev_op, 2);
      chk("R7 refill last", m0.last_op, 1);
      chk("R7 line written back", m0.words[1], 32'hC022_0044);
   endtask

   task automatic t_wb_alloc;
      logic [31:0] rd;
      logic hit;
      int lr;
      lr = m0.n_line_rd;
      access(0, 1'b1, 32'h1A8, 32'hDEAD_BEEF, 4'hF, rd, hit);
      chk("R8 write miss flag", 32'(hit), 0);
      chk("R8 line fetched", m0.n_line_rd, lr + 1);
      chk("R8 no word write", m0.n_word_wr, 0);
      rd_chk(0, 32'h1A8, 1'b1, "R8 merged word");
      rd_chk(0, 32'h1A0, 1'b1, "R8 rest of line");
   endtask

   task automatic t_wt_hit;
      logic [31:0] rd;
      logic hit;
      access(1, 1'b1, 32'h008, 32'hCAFE_F00D, 4'hF, rd, hit);
      chk("R10 write hit flag", 32'(hit), 1);
      chk("R10 word forwarded", m1.n_word_wr, 1);
      chk("R10 memory updated", m1.words[2], 32'hCAFE_F00D);
      rd_chk(1, 32'h008, 1'b1, "R10 cache updated");
      access(1, 1'b1, 32'h00C, 32'hAABB_CCDD, 4'b1000, rd, hit);
      chk("R9 partial write hit", 32'(hit), 1);
      chk("R9 memory bytes", m1.words[3], 32'hAA00_0003);
      rd_chk(1, 32'h00C, 1'b1, "R9 byte merge store-through");
      chk("R10 no line writes", m1.n_line_wr, 0);
   endtask

   task automatic t_wt_miss;
      logic [31:0] rd;
      logic hit;
      int lr;
      lr = m1.n_line_rd;
      access(1, 1'b1, 32'h248, 32'h1234_5678, 4'hF, rd, hit);
      chk("R11 write miss flag", 32'(hit), 0);
      chk("R11 no fill", m1.n_line_rd, lr);
      chk("R11 memory updated", m1.words[32'h92], 32'h1234_5678);
      rd_chk(1, 32'h248, 1'b0, "R11 not installed");
      rd_chk(1, 32'h248, 1'b1, "R11 installed by read");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_cold_miss();
      t_hit_offset();
      t_index_split();
      t_lru();
      t_wb_write_hit();
      t_wb_evict();
      t_wb_alloc();
      t_wt_hit();
      t_wt_miss();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog actual hung expected finished");
         $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end
endmodule